// File: doc/BRIEF.md
# Segmented Trigger Capture Controller

This block sequences a digitizer that stores a run of equal-length segments in sample memory, one segment per trigger. Software programs the total number of samples to keep and the length of one segment. A start command checks the settings and arms the block. Each accepted trigger starts a countdown of sample strobes. When the countdown ends, the block writes one segment of consecutive samples through a write-enable and address pair. It then re-arms for the next trigger, until memory is full or a stop command ends the run.

The countdown is fixed for each configuration. It depends on three settings: the sampling rate mode (base or doubled), whether clock synchronisation is on, and whether the trigger comes from an external logic input or from a channel signal. No samples from before the trigger are kept. The valid-sample count grows only when a segment completes. After an abort, software can therefore read back exactly the span of whole segments in memory.

Top module: `seg_capture_ctrl`

## Requirements
- R1: After reset, and after an accepted start, `busy` is high only once the start has been accepted. `done`, `cfg_err` and `valid_cnt` are 0 after reset and are cleared by an accepted start. The address restarts at 0. A start is only acted on while the block is idle.
- R2: A start is refused, `cfg_err` goes high and `busy` stays low in any of these cases: `cfg_fullmem` is 1, `cfg_seg_len` is 0, `cfg_total` is 0, or `cfg_total` is not an exact multiple of `cfg_seg_len`.
- R3: After an accepted trigger, exactly L sample strobes are discarded, and the next strobe is the first one written. L is set by {`cfg_rate_dbl`, `cfg_trig_chan`, `cfg_sync`}: 000 gives 8, 001 gives 13, 010 gives 16, 011 gives 21, 100 gives 16, 101 gives 26, 110 gives 32, 111 gives 42. The configuration is latched at start.
- R4: Each segment asserts `wr_en` on exactly `cfg_seg_len` strobes, one per strobe and never without a strobe. The addresses are consecutive and continue from the end of the previous segment. Every written address is below `cfg_total`.
- R5: A trigger that arrives during the countdown or while a segment is being written has no effect.
- R6: `valid_cnt` rises by the segment length in the cycle after the last sample of a segment is written, and does not change at any other time except when cleared by a start.
- R7: When the sample at address `cfg_total`-1 is written, `done` goes high and `busy` goes low. Later triggers and strobes write nothing until the next accepted start.
- R8: A stop returns the block to idle from any armed, countdown or writing phase. The strobe in the same cycle as the stop is not written, and no later one is either. `valid_cnt` keeps only the completed segments.
- R9: While the block is armed and waiting for a trigger, strobes write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start command pulse |
| stop | input | 1 | Abort command pulse |
| trig | input | 1 | Qualified trigger pulse |
| smp_stb | input | 1 | One pulse per sample |
| cfg_total | input | TOTAL_W | Total samples to capture |
| cfg_seg_len | input | TOTAL_W | Samples per segment |
| cfg_rate_dbl | input | 1 | 1 = doubled rate mode |
| cfg_sync | input | 1 | 1 = synchronisation enabled |
| cfg_trig_chan | input | 1 | 1 = channel-signal trigger, 0 = external logic trigger |
| cfg_fullmem | input | 1 | Full-memory single-channel mode is enabled |
| wr_en | output | 1 | Sample write enable |
| wr_addr | output | TOTAL_W | Sample write address |
| busy | output | 1 | Run in progress |
| done | output | 1 | Total size filled |
| cfg_err | output | 1 | Last start was refused |
| valid_cnt | output | TOTAL_W | Samples in completed segments |

## Verification
The bench builds the block with TOTAL_W = 6, so that total sizes and segment lengths stay below 64. That small width lets the bench sweep every pair of total size and segment length through the start check, and compare the result against a modulo computed in the bench. All eight latency settings are measured, both with strobes on every cycle and with strobes on alternate cycles. Short multi-segment runs make it cheap to reach full memory, stray triggers, and aborts during the countdown and in the middle of a segment.

// File: rtl/seg_capture_pkg.sv
// Shared types and the trigger-to-sample latency lookup for the segmented
// capture controller. Assumes latencies never exceed MAX_LAT.
package seg_capture_pkg;

    localparam int MAX_LAT = 42;
    localparam int LAT_W   = $clog2(MAX_LAT + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DELAY = 2'd2,
        ST_CAPT  = 2'd3
    } cap_state_t;

    typedef struct packed {
        logic rate_dbl;
        logic trig_chan;
        logic sync;
    } acq_cfg_t;

    // Strobes to discard between trigger and first stored sample.
    function automatic logic [LAT_W-1:0] trig_latency(input acq_cfg_t c);
        logic [LAT_W-1:0] l;
        case ({c.rate_dbl, c.trig_chan, c.sync})
            3'b000:  l = LAT_W'(8);
            3'b001:  l = LAT_W'(13);
            3'b010:  l = LAT_W'(16);
            3'b011:  l = LAT_W'(21);
            3'b100:  l = LAT_W'(16);
            3'b101:  l = LAT_W'(26);
            3'b110:  l = LAT_W'(32);
            default: l = LAT_W'(42);
        endcase
        return l;
    endfunction

endpackage

// File: rtl/seg_cfg_check.sv
// Validates capture settings before a run is armed.
// Assumes the settings are stable in the cycle the start command is seen.
module seg_cfg_check #(
    parameter int TOTAL_W = 16
) (
    input  logic [TOTAL_W-1:0] total,
    input  logic [TOTAL_W-1:0] seg_len,
    input  logic               fullmem,
    output logic               cfg_ok
);

    // Accept only non-zero sizes that divide evenly, with full-memory mode off.
    always_comb begin
        if (fullmem || (seg_len == '0) || (total == '0))
            cfg_ok = 1'b0;
        else
            cfg_ok = ((total % seg_len) == '0);
    end

endmodule

// File: rtl/seg_delay_ctr.sv
// Counts sample strobes after a trigger and flags the strobe that ends the
// fixed latency. Assumes lat is at least 1 and at most MAX_LAT.
module seg_delay_ctr
    import seg_capture_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] lat,
    input  logic             run,
    input  logic             stb,
    output logic             expired
);

    logic [LAT_W-1:0] cnt;

    // Load on trigger, count down once per strobe while the countdown phase is active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= lat;
        else if (run && stb && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    assign expired = run && stb && (cnt == LAT_W'(1));

    assert_delay_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAT_W'(MAX_LAT));

    assert_delay_steps_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && stb && !load && (cnt != '0)) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/seg_addr_gen.sv
// Generates write addresses, tracks the position inside a segment and keeps
// the count of samples in completed segments. Assumes seg_len divides total.
module seg_addr_gen #(
    parameter int TOTAL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr,
    input  logic [TOTAL_W-1:0] seg_len,
    input  logic [TOTAL_W-1:0] total,
    output logic [TOTAL_W-1:0] addr,
    output logic               seg_last,
    output logic               mem_last,
    output logic [TOTAL_W-1:0] valid_cnt
);

    localparam int EXT_W = TOTAL_W + 1;

    logic [TOTAL_W-1:0] seg_idx;
    logic [EXT_W-1:0]   addr_nxt;

    assign addr_nxt = {1'b0, addr} + EXT_W'(1);
    assign seg_last = (seg_idx == seg_len - 1'b1);
    assign mem_last = seg_last && (addr_nxt == {1'b0, total});

    // Advance address and in-segment index on each written sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr    <= '0;
            seg_idx <= '0;
        end else if (wr) begin
            addr    <= addr_nxt[TOTAL_W-1:0];
            seg_idx <= seg_last ? '0 : seg_idx + 1'b1;
        end
    end

    // Credit a whole segment only when its last sample is written.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            valid_cnt <= '0;
        else if (wr && seg_last)
            valid_cnt <= valid_cnt + seg_len;
    end

    assert_addr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (addr < total));

    assert_valid_whole_segments_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(valid_cnt) |-> ((valid_cnt == '0) ||
                                 (valid_cnt == $past(valid_cnt) + $past(seg_len))));

endmodule

// File: rtl/seg_capture_ctrl.sv
// Segmented trigger capture controller: arms on start, waits a fixed
// configuration-dependent latency after each trigger, writes one segment per
// trigger and stops on full memory or on an abort.
// Assumes trig, start and stop are single-cycle pulses in the clk domain.
module seg_capture_ctrl
    import seg_capture_pkg::*;
#(
    parameter int TOTAL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               stop,
    input  logic               trig,
    input  logic               smp_stb,
    input  logic [TOTAL_W-1:0] cfg_total,
    input  logic [TOTAL_W-1:0] cfg_seg_len,
    input  logic               cfg_rate_dbl,
    input  logic               cfg_sync,
    input  logic               cfg_trig_chan,
    input  logic               cfg_fullmem,
    output logic               wr_en,
    output logic [TOTAL_W-1:0] wr_addr,
    output logic               busy,
    output logic               done,
    output logic               cfg_err,
    output logic [TOTAL_W-1:0] valid_cnt
);

    cap_state_t         state;
    acq_cfg_t           live_cfg;
    logic [LAT_W-1:0]   lat_q;
    logic [TOTAL_W-1:0] total_q;
    logic [TOTAL_W-1:0] seg_q;
    logic               cfg_ok;
    logic               accept;
    logic               dly_load;
    logic               dly_exp;
    logic               seg_last;
    logic               mem_last;

    assign live_cfg = '{rate_dbl: cfg_rate_dbl, trig_chan: cfg_trig_chan, sync: cfg_sync};
    assign accept   = (state == ST_IDLE) && start && cfg_ok;
    assign dly_load = (state == ST_ARMED) && trig && !stop;
    assign wr_en    = (state == ST_CAPT) && smp_stb && !stop;
    assign busy     = (state != ST_IDLE);

    seg_cfg_check #(.TOTAL_W(TOTAL_W)) u_check (
        .total   (cfg_total),
        .seg_len (cfg_seg_len),
        .fullmem (cfg_fullmem),
        .cfg_ok  (cfg_ok)
    );

    seg_delay_ctr u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dly_load),
        .lat     (lat_q),
        .run     (state == ST_DELAY),
        .stb     (smp_stb),
        .expired (dly_exp)
    );

    seg_addr_gen #(.TOTAL_W(TOTAL_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .wr        (wr_en),
        .seg_len   (seg_q),
        .total     (total_q),
        .addr      (wr_addr),
        .seg_last  (seg_last),
        .mem_last  (mem_last),
        .valid_cnt (valid_cnt)
    );

    // Latch sizes and latency when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
            seg_q   <= '0;
            lat_q   <= '0;
        end else if (accept) begin
            total_q <= cfg_total;
            seg_q   <= cfg_seg_len;
            lat_q   <= trig_latency(live_cfg);
        end
    end

    // Record the outcome of each start command seen while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else if ((state == ST_IDLE) && start)
            cfg_err <= !cfg_ok;
    end

    // Raise done on filling memory, clear it on the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || accept)
            done <= 1'b0;
        else if (wr_en && mem_last)
            done <= 1'b1;
    end

    // Run phase sequencing: idle, armed, countdown, segment write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (accept) state <= ST_ARMED;
                ST_ARMED: if (stop) state <= ST_IDLE;
                          else if (trig) state <= ST_DELAY;
                ST_DELAY: if (stop) state <= ST_IDLE;
                          else if (dly_exp) state <= ST_CAPT;
                ST_CAPT:  if (stop) state <= ST_IDLE;
                          else if (wr_en && seg_last) state <= mem_last ? ST_IDLE : ST_ARMED;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assert_err_blocks_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy);

    assert_done_means_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_stop_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && busy) |=> !busy);

    assert_write_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (smp_stb && busy));

    assert_no_write_when_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |-> !wr_en);

endmodule

// File: tb/seg_capture_ctrl_tb.sv
module seg_capture_ctrl_tb;

    localparam int W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, stop = 0, trig = 0, smp_stb = 0;
    logic [W-1:0] cfg_total = '0, cfg_seg_len = '0;
    logic cfg_rate_dbl = 0, cfg_sync = 0, cfg_trig_chan = 0, cfg_fullmem = 0;
    logic wr_en, busy, done, cfg_err;
    logic [W-1:0] wr_addr, valid_cnt;

    int n_checks = 0;
    int n_fail = 0;
    logic obs_en;
    logic [W-1:0] obs_addr;

    always #4 clk = ~clk;

    seg_capture_ctrl #(.TOTAL_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .trig(trig),
        .smp_stb(smp_stb), .cfg_total(cfg_total), .cfg_seg_len(cfg_seg_len),
        .cfg_rate_dbl(cfg_rate_dbl), .cfg_sync(cfg_sync), .cfg_trig_chan(cfg_trig_chan),
        .cfg_fullmem(cfg_fullmem), .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy),
        .done(done), .cfg_err(cfg_err), .valid_cnt(valid_cnt)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, capture combinational outputs, pass the edge.
    task automatic tick(input logic t, input logic s, input logic st, input logic sp);
        @(negedge clk);
        trig = t; smp_stb = s; start = st; stop = sp;
        #1;
        obs_en = wr_en;
        obs_addr = wr_addr;
        @(posedge clk);
        #1;
        trig = 0; smp_stb = 0; start = 0; stop = 0;
    endtask

    function automatic int lat_of(input int d, input int ch, input int sy);
        int base;
        base = (ch != 0) ? (sy != 0 ? 21 : 16) : (sy != 0 ? 13 : 8);
        return (d != 0) ? 2 * base : base;
    endfunction

    // Trigger, then strobe until one segment is written; check latency and addresses.
    task automatic run_segment(input int base, input int lat, input int seg,
                               input int gap, input int inject);
        int disc = 0;
        int wrote = 0;
        int cyc = 0;
        tick(1, 0, 0, 0);
        while (wrote < seg && cyc < 400) begin
            logic s;
            logic t;
            s = (gap == 0) || (cyc % 2 == 0);
            t = (inject != 0) && s && ((disc == 3 && wrote == 0) || wrote == 1);
            tick(t, s, 0, 0);
            if (obs_en) begin
                chk(s, "R4 write without strobe", 0, 1);
                chk(obs_addr == W'(base + wrote), "R4 address", obs_addr, base + wrote);
                wrote++;
            end else if (s) begin
                if (wrote == 0) disc++;
                else chk(0, "R4 strobe skipped inside segment", 0, 1);
            end
            cyc++;
        end
        chk(disc == lat, (inject != 0) ? "R5 latency with stray trigger" : "R3 latency",
            disc, lat);
        chk(wrote == seg, "R4 segment length", wrote, seg);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!busy && !done && !cfg_err && valid_cnt == 0 && !wr_en, "R1 reset state",
            {busy, done, cfg_err}, 0);

        // R2: sweep every total/segment pair through the start check
        for (int t = 0; t < 64; t++) begin
            for (int s = 0; s < 64; s++) begin
                logic exp_err;
                cfg_total = W'(t); cfg_seg_len = W'(s); cfg_fullmem = 0;
                exp_err = (s == 0) || (t == 0) || ((t % s) != 0);
                tick(0, 0, 1, 0);
                chk(cfg_err == exp_err && busy == !exp_err, "R2 divisibility check",
                    {cfg_err, busy}, {exp_err, !exp_err});
                tick(0, 0, 0, 1);
            end
        end
        // R2: full-memory mode always refuses
        for (int t = 1; t < 64; t++) begin
            cfg_total = W'(t); cfg_seg_len = 1; cfg_fullmem = 1;
            tick(0, 0, 1, 0);
            chk(cfg_err && !busy, "R2 fullmem refused", {cfg_err, busy}, 2);
        end
        cfg_fullmem = 0;

        // R3: every latency setting, continuous and alternate strobes
        for (int d = 0; d < 2; d++)
            for (int ch = 0; ch < 2; ch++)
                for (int sy = 0; sy < 2; sy++)
                    for (int g = 0; g < 2; g++) begin
                        cfg_total = 2; cfg_seg_len = 2;
                        cfg_rate_dbl = d[0]; cfg_trig_chan = ch[0]; cfg_sync = sy[0];
                        tick(0, 0, 1, 0);
                        cfg_rate_dbl = ~cfg_rate_dbl; // latched at start
                        run_segment(0, lat_of(d, ch, sy), 2, g, 0);
                        chk(done && !busy && valid_cnt == 2, "R7 done after single segment",
                            valid_cnt, 2);
                    end
        cfg_rate_dbl = 0; cfg_trig_chan = 0; cfg_sync = 0;

        // Three-segment run with stray triggers and pre-trigger strobes
        cfg_total = 12; cfg_seg_len = 4;
        tick(0, 0, 1, 0);
        chk(busy && !done && !cfg_err && valid_cnt == 0, "R1 start clears", valid_cnt, 0);
        run_segment(0, 8, 4, 0, 1);
        chk(valid_cnt == 4 && busy && !done, "R6 count after segment 1", valid_cnt, 4);
        for (int i = 0; i < 5; i++) begin
            tick(0, 1, 0, 0);
            chk(!obs_en, "R9 no write while armed", obs_en, 0);
        end
        chk(valid_cnt == 4, "R6 count steady while armed", valid_cnt, 4);
        run_segment(4, 8, 4, 0, 0);
        chk(valid_cnt == 8, "R6 count after segment 2", valid_cnt, 8);
        run_segment(8, 8, 4, 1, 1);
        chk(valid_cnt == 12 && done && !busy, "R7 full memory", valid_cnt, 12);
        tick(1, 0, 0, 0);
        for (int i = 0; i < 60; i++) begin
            tick(0, 1, 0, 0);
            chk(!obs_en, "R7 no write after done", obs_en, 0);
        end
        chk(valid_cnt == 12 && done, "R7 state held after done", valid_cnt, 12);

        // R8: abort in the middle of a segment
        tick(0, 0, 1, 0);
        chk(valid_cnt == 0 && !done && busy, "R1 restart clears", valid_cnt, 0);
        run_segment(0, 8, 4, 0, 0);
        tick(1, 0, 0, 0);
        for (int i = 0; i < 10; i++) tick(0, 1, 0, 0);
        chk(obs_en && obs_addr == 5, "R4 partial segment address", obs_addr, 5);
        tick(0, 1, 0, 1);
        chk(!obs_en, "R8 strobe with stop not written", obs_en, 0);
        chk(!busy && valid_cnt == 4, "R8 partial segment not counted", valid_cnt, 4);
        tick(1, 0, 0, 0);
        for (int i = 0; i < 60; i++) begin
            tick(0, 1, 0, 0);
            chk(!obs_en, "R8 no write after stop", obs_en, 0);
        end
        chk(valid_cnt == 4 && !done, "R8 count held after stop", valid_cnt, 4);

        // R8: abort during the countdown
        tick(0, 0, 1, 0);
        tick(1, 0, 0, 0);
        for (int i = 0; i < 3; i++) tick(0, 1, 0, 0);
        tick(0, 0, 0, 1);
        chk(!busy && valid_cnt == 0, "R8 stop in countdown", valid_cnt, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule